// File: doc/BRIEF.md
# Asynchronous-Port Static Memory Model

This block is a synthesizable model of a word-wide static memory whose port follows the usual asynchronous convention. It has three active-low controls: a chip select, an output gate and a write strobe. It also has a binary address and a data bus that is split into an input vector, an output vector and a drive flag. Inputs are sampled on a system clock. Read data is a purely combinational function of the current address and controls, so the model behaves like an asynchronous part whose timing is counted in whole clock periods.

The full geometry is 2^18 words of 4 bits. The storage is held as rows by column groups: the upper index bits pick a row and the lower index bits pick one word inside it. Simulation usually uses a smaller array. A parameter sets the number of index bits, and the address bits above them are not decoded. A second parameter chooses how a write reaches the array. It can be held in a pending register until the write window closes and forwarded to reads meanwhile, or it can be written through on every sampled cycle of the window. Both choices look the same at the ports.

Top module: `async_sram_model`

## Requirements
- R1: While `ce_n` is 1, `dq_oe` is 0 and `dout` is all zeros, whatever `oe_n` and `we_n` are; this includes the cycles right after reset.
- R2: With `ce_n`=0, `oe_n`=1 and `we_n`=1, the bus is not driven: `dq_oe`=0 and `dout`=0.
- R3: With `ce_n`=0, `oe_n`=0 and `we_n`=1, `dq_oe`=1 and `dout` shows the stored word for the current address in that same cycle, following any change of address with no clock delay.
- R4: With `ce_n`=0 and `we_n`=0 the cycle is a write whatever `oe_n` is, and `dq_oe` stays 0 for every cycle of the write, including when `oe_n` falls together with or after `we_n`.
- R5: A write window lasts for as many clock edges as both `ce_n` and `we_n` are sampled low. The word stored is the `din` sampled at the last edge of the window. The window may end by `ce_n` rising or by `we_n` rising.
- R6: A read of the written address in the first cycle after a write window closes returns the newly written word.
- R7: `we_n`=0 while `ce_n`=1 changes no stored word.
- R8: Only the low `ARRAY_LOG2` address bits (default 10) select a word; addresses that differ only above them reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the write path |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W (18) | Word address |
| din | input | DATA_W (4) | Data presented for writing |
| dout | output | DATA_W (4) | Read data, zero when not driving |
| dq_oe | output | 1 | High when the model drives the bus |

## Verification
The inline assertions check the mode rules on every cycle: a deselected part is quiet, a gated-off read does not drive, a write never drives, a read always drives, a closing write window always commits, and a read of a just-committed address returns the committed word. Only the bench scenarios can show the data side: that a full fill of the array reads back intact, that the last sampled data of a multi-cycle window wins for both ways of ending it, that a write strobe without select leaves contents untouched, and that high address bits alias.

// File: rtl/sram_pkg.sv
package sram_pkg;

   typedef enum logic [1:0] {
      SR_DESEL = 2'd0,
      SR_HIZ   = 2'd1,
      SR_READ  = 2'd2,
      SR_WRITE = 2'd3
   } sr_mode_e;

endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
   import sram_pkg::*;
(
   input  logic     ce_n,
   input  logic     oe_n,
   input  logic     we_n,
   output sr_mode_e mode,
   output logic     drive,
   output logic     wr_window
);

   always_comb begin
      if (ce_n)      mode = SR_DESEL;
      else if (!we_n) mode = SR_WRITE;
      else if (oe_n)  mode = SR_HIZ;
      else            mode = SR_READ;
   end

   assign drive     = (mode == SR_READ);
   assign wr_window = (mode == SR_WRITE);

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl #(
   parameter int IDX_W        = 10,
   parameter int DATA_W       = 4,
   parameter bit DEFER_COMMIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_window,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] din,
   output logic              cm_en,
   output logic [IDX_W-1:0]  cm_idx,
   output logic [DATA_W-1:0] cm_data,
   output logic              fw_vld,
   output logic [IDX_W-1:0]  fw_idx,
   output logic [DATA_W-1:0] fw_data
);

   generate
      if (DEFER_COMMIT) begin : g_defer
         logic              pend_vld;
         logic [IDX_W-1:0]  pend_idx;
         logic [DATA_W-1:0] pend_data;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_vld <= 1'b0;
            end else if (wr_window) begin
               pend_vld  <= 1'b1;
               pend_idx  <= idx;
               pend_data <= din;
            end else if (pend_vld) begin
               pend_vld <= 1'b0;
            end
         end

         assign cm_en   = pend_vld && !wr_window;
         assign cm_idx  = pend_idx;
         assign cm_data = pend_data;
         assign fw_vld  = pend_vld;
         assign fw_idx  = pend_idx;
         assign fw_data = pend_data;

         // R5
         window_close_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(wr_window) && !wr_window) |-> cm_en);

         // R5
         no_commit_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_window |-> !cm_en);
      end else begin : g_through
         logic wt_unused;
         assign wt_unused = clk ^ rst_n;
         assign cm_en   = wr_window;
         assign cm_idx  = idx;
         assign cm_data = din;
         assign fw_vld  = 1'b0;
         assign fw_idx  = '0;
         assign fw_data = '0;
      end
   endgenerate

endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
   parameter int ROW_W  = 5,
   parameter int COL_W  = 5,
   parameter int DATA_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [ROW_W+COL_W-1:0]  w_idx,
   input  logic [DATA_W-1:0]       w_data,
   input  logic [ROW_W+COL_W-1:0]  r_idx,
   input  logic                    fw_vld,
   input  logic [ROW_W+COL_W-1:0]  fw_idx,
   input  logic [DATA_W-1:0]       fw_data,
   output logic [DATA_W-1:0]       r_data
);

   localparam int IDX_W = ROW_W + COL_W;
   localparam int ROWS  = 1 << ROW_W;
   localparam int COLS  = 1 << COL_W;

   logic [DATA_W-1:0] cells [ROWS][COLS];
   logic [ROW_W-1:0]  w_row, r_row;
   logic [COL_W-1:0]  w_col, r_col;
   logic [DATA_W-1:0] cell_q;

   assign w_row = w_idx[IDX_W-1 -: ROW_W];
   assign w_col = w_idx[COL_W-1:0];
   assign r_row = r_idx[IDX_W-1 -: ROW_W];
   assign r_col = r_idx[COL_W-1:0];

   always_ff @(posedge clk) begin
      if (we) cells[w_row][w_col] <= w_data;
   end

   assign cell_q = cells[r_row][r_col];
   assign r_data = (fw_vld && (fw_idx == r_idx)) ? fw_data : cell_q;

   // R6
   read_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((r_idx != $past(w_idx)) || (r_data == $past(w_data))));

endmodule

// File: rtl/async_sram_model.sv
module async_sram_model
   import sram_pkg::*;
#(
   parameter int ADDR_W       = 18,
   parameter int DATA_W       = 4,
   parameter int ARRAY_LOG2   = 10,
   parameter int ROW_LOG2     = 5,
   parameter bit DEFER_COMMIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dq_oe
);

   localparam int IDX_W    = ARRAY_LOG2;
   localparam int COL_LOG2 = ARRAY_LOG2 - ROW_LOG2;

   initial begin
      assert (DATA_W >= 1) else $error("data width must be positive");
      assert (ARRAY_LOG2 <= ADDR_W) else $error("array larger than address space");
      assert (ROW_LOG2 >= 1 && COL_LOG2 >= 1) else $error("row/column split invalid");
   end

   sr_mode_e          mode;
   logic              drive;
   logic              wr_window;
   logic [IDX_W-1:0]  idx;
   logic              cm_en;
   logic [IDX_W-1:0]  cm_idx;
   logic [DATA_W-1:0] cm_data;
   logic              fw_vld;
   logic [IDX_W-1:0]  fw_idx;
   logic [DATA_W-1:0] fw_data;
   logic [DATA_W-1:0] rd_word;

   assign idx = addr[IDX_W-1:0];

   generate
      if (ADDR_W > IDX_W) begin : g_alias
         logic hi_bits_unused;
         assign hi_bits_unused = ^addr[ADDR_W-1:IDX_W];
      end
   endgenerate

   sram_mode_dec i_dec (
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .we_n      (we_n),
      .mode      (mode),
      .drive     (drive),
      .wr_window (wr_window)
   );

   sram_wr_ctrl #(
      .IDX_W        (IDX_W),
      .DATA_W       (DATA_W),
      .DEFER_COMMIT (DEFER_COMMIT)
   ) i_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_window (wr_window),
      .idx       (idx),
      .din       (din),
      .cm_en     (cm_en),
      .cm_idx    (cm_idx),
      .cm_data   (cm_data),
      .fw_vld    (fw_vld),
      .fw_idx    (fw_idx),
      .fw_data   (fw_data)
   );

   sram_bank #(
      .ROW_W  (ROW_LOG2),
      .COL_W  (COL_LOG2),
      .DATA_W (DATA_W)
   ) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cm_en),
      .w_idx   (cm_idx),
      .w_data  (cm_data),
      .r_idx   (idx),
      .fw_vld  (fw_vld),
      .fw_idx  (fw_idx),
      .fw_data (fw_data),
      .r_data  (rd_word)
   );

   assign dq_oe = drive;
   assign dout  = drive ? rd_word : '0;

   // R1
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (!dq_oe && dout == '0));

   // R2
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && oe_n && we_n) |-> (!dq_oe && dout == '0));

   // R3
   read_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && we_n) |-> dq_oe);

   // R4
   write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !we_n) |-> !dq_oe);

endmodule

// File: tb/test_async_sram_model.sv
`timescale 1ns/1ps
module test_async_sram_model;

   localparam int AW = 18;
   localparam int DW = 4;
   localparam int AL = 10;
   localparam int N  = 1 << AL;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ce_n, oe_n, we_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] din;
   logic [DW-1:0] dout;
   logic          dq_oe;

   int  tests = 0;
   int  fails = 0;
   bit  done  = 0;

   logic [DW-1:0] ref_mem [N];
   bit            ref_known [N];

   always #5 clk = ~clk;

   async_sram_model i_async_sram_model (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe)
   );

   // reference: a selected, strobed edge stores din at the low index bits (R5, R7, R8)
   always @(posedge clk) begin
      if (rst_n && !ce_n && !we_n) begin
         ref_mem[addr[AL-1:0]]   <= din;
         ref_known[addr[AL-1:0]] <= 1'b1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_now();
      int idx = int'(addr[AL-1:0]);
      if (ce_n) begin
         chk(!dq_oe && dout == '0, "R1 deselect", {dq_oe, dout}, 0);
      end else if (!we_n) begin
         chk(!dq_oe && dout == '0, "R4 write no drive", {dq_oe, dout}, 0);
      end else if (oe_n) begin
         chk(!dq_oe && dout == '0, "R2 gate off", {dq_oe, dout}, 0);
      end else begin
         chk(dq_oe == 1'b1, "R3 read drive", dq_oe, 1);
         if (ref_known[idx])
            chk(dout == ref_mem[idx], "R3 read data", dout, ref_mem[idx]);
      end
   endtask

   task automatic step(input logic c, input logic o, input logic w,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      ce_n = c; oe_n = o; we_n = w; addr = a; din = d;
      #2;
      compare_now();
   endtask

   task automatic rd_expect(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
      step(1'b0, 1'b0, 1'b1, a, '0);
      chk(dq_oe && dout == e, tag, dout, e);
   endtask

   function automatic logic [DW-1:0] pat(input int i);
      return DW'(i ^ (i >> 4) ^ 5);
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) ref_known[i] = 1'b0;
      rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b0; addr = '0; din = '1;
      repeat (3) @(posedge clk);
      #2;
      chk(!dq_oe && dout == '0, "R1 reset state", {dq_oe, dout}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // fill with random high address bits and oe_n toggling (R4, R8)
      for (int i = 0; i < N; i++) begin
         step(1'b0, 1'(i), 1'b0, {8'($urandom), 10'(i)}, pat(i));
         step(1'b1, 1'b1, 1'b1, '0, '0);
      end

      // sweep reads, address changing every cycle (R3)
      for (int i = 0; i < 300; i++) begin
         logic [AW-1:0] a = AW'($urandom);
         step(1'b0, 1'b0, 1'b1, a, '0);
      end
      rd_expect(18'h00011, pat(17), "R3 follow addr A");
      rd_expect(18'h00222, pat(546), "R3 follow addr B");

      // deselect with every gate/strobe combination (R1), strobe without select (R7)
      step(1'b1, 1'b0, 1'b0, 18'h00040, ~pat(64));
      step(1'b1, 1'b0, 1'b1, 18'h00040, ~pat(64));
      step(1'b1, 1'b1, 1'b0, 18'h00040, ~pat(64));
      step(1'b1, 1'b1, 1'b1, 18'h00040, ~pat(64));
      rd_expect(18'h00040, pat(64), "R7 unselected strobe ignored");

      // output gated off (R2)
      step(1'b0, 1'b1, 1'b1, 18'h00040, '0);
      chk(!dq_oe && dout == '0, "R2 gated", {dq_oe, dout}, 0);

      // write ended by strobe, data changes across window (R5), read next cycle (R6)
      step(1'b0, 1'b1, 1'b0, 18'h00100, 4'h1);
      step(1'b0, 1'b1, 1'b0, 18'h00100, 4'h2);
      step(1'b0, 1'b1, 1'b0, 18'h00100, 4'h9);
      rd_expect(18'h00100, 4'h9, "R5 R6 strobe-ended last data");

      // write ended by select rising while strobe held (R5)
      step(1'b0, 1'b1, 1'b0, 18'h00155, 4'h3);
      step(1'b0, 1'b1, 1'b0, 18'h00155, 4'hC);
      step(1'b1, 1'b1, 1'b0, 18'h00155, 4'h0);
      rd_expect(18'h00155, 4'hC, "R5 select-ended last data");

      // gate falls during write: still no drive (R4)
      step(1'b0, 1'b1, 1'b0, 18'h002AA, 4'h5);
      step(1'b0, 1'b0, 1'b0, 18'h002AA, 4'h6);
      chk(!dq_oe, "R4 gate falls in write", dq_oe, 0);
      step(1'b0, 1'b0, 1'b0, 18'h002AA, 4'h6);
      chk(!dq_oe, "R4 gate with strobe", dq_oe, 0);
      rd_expect(18'h002AA, 4'h6, "R6 read after write");

      // aliasing of high address bits (R8)
      step(1'b0, 1'b1, 1'b0, {8'hA5, 10'h03C}, 4'h7);
      step(1'b1, 1'b1, 1'b1, '0, '0);
      rd_expect({8'h00, 10'h03C}, 4'h7, "R8 alias low");
      rd_expect({8'hFF, 10'h03C}, 4'h7, "R8 alias high");
      rd_expect(18'h0003D, pat(61), "R8 neighbour intact");

      step(1'b1, 1'b1, 1'b1, '0, '0);
      chk(!dq_oe && dout == '0, "R1 final idle", {dq_oe, dout}, 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule